// File: doc/BRIEF.md
# Three-Class Interrupt Controller with Vectored Slots

This block gathers up to 32 interrupt request lines and sends each one, under software control, to one of three classes. A source whose class bit is set joins the fast class, and all fast-class requests are ORed onto a single fast output. Any other enabled source raises the normal output. That source is vectored when an enabled slot names it, and non-vectored when no enabled slot does. Software can change the enable mask, the class bits and the slot contents at any moment, and each change applies from the next clock.

Software reaches the block over a plain synchronous read/write register bus. Sixteen slots each hold a source index, an enable bit and a handler address. A lower slot number has higher priority. A read of the vector register returns the address held by the best active slot. If no slot qualifies, the read returns a default address for the shared handler. A read that returns a slot's address also marks that slot as in service. From then on only slots with a lower number can win, until a write to the vector register closes the most recent service.

Register word addresses (`addr_i`) are as follows:
- 0x00: raw inputs, read only.
- 0x01: enable mask.
- 0x02: fast-class select.
- 0x03: fast status, read only.
- 0x04: normal status, read only.
- 0x05: vector. A read returns the current vector; a write ends the current service.
- 0x06: default vector.
- 0x10+k: control word for slot k.
- 0x20+k: address for slot k.

Top module: `irq_class_ctrl`

## Requirements
- R1: After reset both outputs are low. The enable mask, class select, default vector and slot words all read 0, and no slot is in service.
- R2: A read of address 0x00 returns `irq_i` as it is, whatever the mask and class settings.
- R3: A source whose bit in the enable mask (0x01, bit i for source i) is 0 affects neither output nor either status word.
- R4: A source that is enabled and has its bit set in the class select (0x02) is in the fast class. `fiq_o` is the OR of all such requests, and those requests never raise `irq_o`.
- R5: A read of 0x03 returns the requesting enabled fast-class sources, one bit per source.
- R6: `irq_o` is the OR of all requesting enabled sources that are not in the fast class, vectored or not. A read of 0x04 returns them one bit per source.
- R7: The control word of slot k (0x10+k) holds the source index in bits [SRC_W-1:0] and the slot enable in bit 8; its address word is at 0x20+k. A slot is active when it is enabled and its source is set in the normal status. A source in the fast class therefore never activates a slot.
- R8: A read of 0x05 returns the address of the lowest-numbered active slot that may currently win. If no slot qualifies, the read returns the default vector (0x06).
- R9: A vector read that returns a slot's address marks that slot as in service. While any slot is in service, only slots numbered below the lowest in-service slot may win; the rest yield the default vector.
- R10: A write to 0x05 ends service of the lowest-numbered in-service slot, so equal and lower priorities compete again.
- R11: A change to the class select takes effect on the outputs in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_SRC | Request lines, one per source, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (vector reads have side effects) |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, valid in the same cycle |
| fiq_o | output | 1 | Fast-class interrupt to the core |
| irq_o | output | 1 | Normal-class interrupt to the core |

## Verification
The bench builds the block with N_SRC=8 and N_SLOT=4. At that size every slot, including the last, can be programmed, and source indices in the slot words are three bits wide. With only four slots, a short directed sequence can nest two services and then find every remaining slot blocked, so the default-vector fallback appears under in-service blocking. The same sequence also reaches it when the named source is fast-class or the slot is disabled.

// File: rtl/irq_class_pkg.sv
package irq_class_pkg;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_RAW   = 6'h00;
  localparam logic [AW-1:0] A_EN    = 6'h01;
  localparam logic [AW-1:0] A_FSEL  = 6'h02;
  localparam logic [AW-1:0] A_FSTAT = 6'h03;
  localparam logic [AW-1:0] A_ISTAT = 6'h04;
  localparam logic [AW-1:0] A_VEC   = 6'h05;
  localparam logic [AW-1:0] A_DEF   = 6'h06;
  localparam logic [1:0] PG_CTRL = 2'b01;
  localparam logic [1:0] PG_ADDR = 2'b10;
  localparam int CTRL_EN_BIT = 8;
endpackage

// File: rtl/irq_class_sort.sv
module irq_class_sort #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] fsel_i,
  output logic [N_SRC-1:0] fstat_o,
  output logic [N_SRC-1:0] istat_o,
  output logic             fiq_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] live;
  assign live    = req_i & en_i;
  assign fstat_o = live & fsel_i;
  assign istat_o = live & ~fsel_i;
  assign fiq_o   = |fstat_o;
  assign irq_o   = |istat_o;

  // R4
  fast_not_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel_i == en_i && en_i == req_i) |-> !irq_o);
  // R3
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (!fiq_o && !irq_o));
endmodule

// File: rtl/irq_slot_arb.sv
module irq_slot_arb #(
  parameter int N_SLOT = 16,
  localparam int IW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SLOT-1:0] hit_i,
  input  logic [N_SLOT-1:0] allow_i,
  output logic              win_valid_o,
  output logic [IW-1:0]     win_idx_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int k = N_SLOT - 1; k >= 0; k--) begin
      if (hit_i[k] && allow_i[k]) begin
        win_valid_o = 1'b1;
        win_idx_o   = IW'(k);
      end
    end
  end

  // R8
  win_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (hit_i[win_idx_o] && allow_i[win_idx_o]));
  // R8
  none_lost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hit_i & allow_i)) |-> win_valid_o);
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track #(
  parameter int N_SLOT = 16,
  localparam int IW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic [IW-1:0]     ack_idx_i,
  input  logic              eoi_i,
  output logic [N_SLOT-1:0] allow_o
);
  logic [N_SLOT-1:0] in_svc_q, seen;

  assign seen[0] = in_svc_q[0];
  for (genvar k = 1; k < N_SLOT; k++) begin : g_pref
    assign seen[k] = seen[k-1] | in_svc_q[k];
  end
  assign allow_o = ~seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    in_svc_q <= '0;
    else if (eoi_i) in_svc_q <= in_svc_q & (in_svc_q - 1'b1);
    else if (ack_i) in_svc_q[ack_idx_i] <= 1'b1;
  end

  // R9
  ack_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !eoi_i) |=> in_svc_q[$past(ack_idx_i)]);
  // R10
  eoi_pops_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && (|in_svc_q)) |=> ($countones(in_svc_q) == $countones($past(in_svc_q)) - 1));
endmodule

// File: rtl/irq_class_ctrl.sv
module irq_class_ctrl
  import irq_class_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int IW    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [5:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             fiq_o,
  output logic             irq_o
);
  logic [N_SRC-1:0]  en_q, fsel_q, fstat, istat;
  logic [DW-1:0]     def_q;
  logic [SRC_W-1:0]  slot_src_q  [N_SLOT];
  logic [DW-1:0]     slot_addr_q [N_SLOT];
  logic [N_SLOT-1:0] slot_en_q, hit, allow;
  logic              win_valid, vec_rd, ack, eoi;
  logic [IW-1:0]     win_idx;
  logic [DW-1:0]     cur_vec;

  irq_class_sort #(.N_SRC(N_SRC)) u_sort (
    .clk_i, .rst_ni, .req_i(irq_i), .en_i(en_q), .fsel_i(fsel_q),
    .fstat_o(fstat), .istat_o(istat), .fiq_o, .irq_o
  );

  for (genvar k = 0; k < N_SLOT; k++) begin : g_hit
    assign hit[k] = slot_en_q[k] && (int'(slot_src_q[k]) < N_SRC) && istat[slot_src_q[k]];
  end

  irq_slot_arb #(.N_SLOT(N_SLOT)) u_arb (
    .clk_i, .rst_ni, .hit_i(hit), .allow_i(allow),
    .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  assign vec_rd  = rd_en_i && !wr_en_i && (addr_i == A_VEC);
  assign ack     = vec_rd && win_valid;
  assign eoi     = wr_en_i && (addr_i == A_VEC);
  assign cur_vec = win_valid ? slot_addr_q[win_idx] : def_q;

  irq_nest_track #(.N_SLOT(N_SLOT)) u_nest (
    .clk_i, .rst_ni, .ack_i(ack), .ack_idx_i(win_idx), .eoi_i(eoi), .allow_o(allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      fsel_q    <= '0;
      def_q     <= '0;
      slot_en_q <= '0;
      for (int k = 0; k < N_SLOT; k++) begin
        slot_src_q[k]  <= '0;
        slot_addr_q[k] <= '0;
      end
    end else if (wr_en_i) begin
      case (addr_i)
        A_EN:    en_q   <= wdata_i[N_SRC-1:0];
        A_FSEL:  fsel_q <= wdata_i[N_SRC-1:0];
        A_DEF:   def_q  <= wdata_i;
        default: ;
      endcase
      for (int k = 0; k < N_SLOT; k++) begin
        if (addr_i == {PG_CTRL, 4'(k)}) begin
          slot_src_q[k] <= wdata_i[SRC_W-1:0];
          slot_en_q[k]  <= wdata_i[CTRL_EN_BIT];
        end
        if (addr_i == {PG_ADDR, 4'(k)}) slot_addr_q[k] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RAW:   rdata_o = 32'(irq_i);
      A_EN:    rdata_o = 32'(en_q);
      A_FSEL:  rdata_o = 32'(fsel_q);
      A_FSTAT: rdata_o = 32'(fstat);
      A_ISTAT: rdata_o = 32'(istat);
      A_VEC:   rdata_o = cur_vec;
      A_DEF:   rdata_o = def_q;
      default: ;
    endcase
    for (int k = 0; k < N_SLOT; k++) begin
      if (addr_i == {PG_CTRL, 4'(k)}) begin
        rdata_o[SRC_W-1:0]  = slot_src_q[k];
        rdata_o[CTRL_EN_BIT] = slot_en_q[k];
      end
      if (addr_i == {PG_ADDR, 4'(k)}) rdata_o = slot_addr_q[k];
    end
  end

  // R6
  vec_needs_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> irq_o);
  // R4
  fiq_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (|fsel_q));
  // R11
  fsel_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_FSEL && wdata_i[N_SRC-1:0] == '0) |=> !fiq_o);
endmodule

// File: tb/irq_class_ctrl_bench.sv
module irq_class_ctrl_bench;
  localparam int NS = 8;
  localparam int NL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic fiq, irq_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_class_ctrl #(.N_SRC(NS), .N_SLOT(NL)) u_irq_class_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_irq(input logic [NS-1:0] v);
    @(negedge clk);
    irq = v;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 fiq", 32'(fiq), 0);
    chk("R1 irq", 32'(irq_out), 0);
    rd(6'h01, d); chk("R1 en", d, 0);
    rd(6'h02, d); chk("R1 fsel", d, 0);
    rd(6'h05, d); chk("R1 vec", d, 0);
    rd(6'h12, d); chk("R1 slot", d, 0);
  endtask

  task automatic t_raw_mask();
    logic [31:0] d;
    set_irq(8'hA5);
    rd(6'h00, d); chk("R2 raw", d, 32'hA5);
    chk("R3 masked irq", 32'(irq_out), 0);
    chk("R3 masked fiq", 32'(fiq), 0);
    rd(6'h04, d); chk("R3 masked stat", d, 0);
    wr(6'h01, 32'h0F);
    rd(6'h00, d); chk("R2 raw unmasked", d, 32'hA5);
    rd(6'h04, d); chk("R6 istat", d, 32'h05);
    chk("R6 irq", 32'(irq_out), 1);
  endtask

  task automatic t_fast();
    logic [31:0] d;
    wr(6'h02, 32'h04);
    chk("R4 fiq", 32'(fiq), 1);
    rd(6'h03, d); chk("R5 fstat", d, 32'h04);
    rd(6'h04, d); chk("R6 istat excl fast", d, 32'h01);
    set_irq(8'h04);
    chk("R4 no irq from fast", 32'(irq_out), 0);
    chk("R4 fiq only", 32'(fiq), 1);
    wr(6'h02, 32'h00);
    chk("R11 moved irq", 32'(irq_out), 1);
    chk("R11 moved fiq", 32'(fiq), 0);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    wr(6'h01, 32'hFF);
    wr(6'h06, 32'h100);
    wr(6'h10, 32'h105); wr(6'h20, 32'hA0);
    wr(6'h11, 32'h102); wr(6'h21, 32'hB0);
    wr(6'h12, 32'h006); wr(6'h22, 32'hC0);
    rd(6'h10, d); chk("R7 ctrl readback", d, 32'h105);
    rd(6'h06, d); chk("R8 def readback", d, 32'h100);
    set_irq(8'h04);
    rd(6'h05, d); chk("R8 slot1", d, 32'hB0);
    set_irq(8'h24);
    rd(6'h05, d); chk("R9 nest slot0", d, 32'hA0);
    rd(6'h05, d); chk("R9 blocked", d, 32'h100);
    wr(6'h05, 0);
    rd(6'h05, d); chk("R10 slot0 again", d, 32'hA0);
    wr(6'h05, 0);
    wr(6'h05, 0);
    set_irq(8'h04);
    rd(6'h05, d); chk("R10 slot1 again", d, 32'hB0);
    wr(6'h05, 0);
    set_irq(8'h40);
    chk("R6 nonvectored irq", 32'(irq_out), 1);
    rd(6'h05, d); chk("R7 disabled slot", d, 32'h100);
    wr(6'h02, 32'h20);
    set_irq(8'h20);
    rd(6'h05, d); chk("R7 fast source skips slot", d, 32'h100);
    chk("R4 fast source fiq", 32'(fiq), 1);
    wr(6'h02, 32'h00);
    rd(6'h05, d); chk("R8 slot0 after reclass", d, 32'hA0);
    wr(6'h05, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw_mask();
    t_fast();
    t_vector();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule